// File: doc/BRIEF.md
# Profiled DDS phase engine

This block is the digital phase path of a direct digital synthesizer. It runs at the sample rate. Each clock it adds a 32-bit frequency word to a phase accumulator. It then adds a 14-bit phase offset to the top of the accumulator and emits the result as a phase word. The upper 10 bits of that word form the address for a downstream sine table and DAC.

Eight profile registers can be chosen with a 3-bit select input. Depending on a control bit, the chosen profile supplies either the frequency word or the phase offset. Two further modes are available:
- A modulus mode makes the accumulator wrap at a programmed value, so the output frequency can be an exact rational fraction of the clock.
- A linear sweep mode steps the frequency word from a start value toward an end value at a programmed rate, then holds it at the end value.

Software writes the settings into holding registers through a simple write port. A single update strobe then copies all the held settings into the working registers on the same clock edge.

Top module: `dds_phase_engine`

## Requirements
- R1: Synchronous reset clears the accumulator, the sweep state, the registered profile select and every holding and working register. After reset is released with nothing programmed, `phase_word` stays 0.
- R2: On each clock the accumulator adds the selected frequency word modulo 2^32. `phase_word` equals accumulator bits [31:18] plus the selected offset, taken modulo 2^14. `lut_addr` equals `phase_word[13:4]`.
- R3: A write changes only a holding register. The working registers take all holding values together on a clock edge where `upd_stb` is high. Until that edge the output is unaffected.
- R4: Register addresses:
  - 0 is control: bit 0 enables modulus mode, bit 1 enables the sweep, and bit 2 selects phase-profile mode.
  - 1 is the base frequency word, and 2 is the base offset (bits 13:0).
  - 3 is the modulus.
  - 4, 5 and 6 are the sweep start, end and step.
  - 7 is the sweep rate (bits 15:0).
  - 8 to 15 are profiles 0 to 7.
- R5: With control bit 2 clear, the frequency word comes from the selected profile and the offset comes from the base offset register.
- R6: With control bit 2 set, the frequency word comes from the base frequency register and the offset comes from bits 13:0 of the selected profile.
- R7: The profile select is registered. A new offset shows after the first clock edge that follows a select change. A new frequency word governs accumulator steps from the second edge onward. The accumulator is never reset by a profile change.
- R8: In modulus mode, when the accumulator plus the frequency word is at least the modulus, the modulus is subtracted from the sum. With a frequency word below the modulus, the accumulator stays below the modulus.
- R9: An update edge at which held control bit 1 is set loads the sweep frequency with the held start value and restarts the rate counter. While working control bit 1 is set, the sweep frequency replaces the frequency word.
- R10: While sweeping, the sweep frequency grows by the step once every max(rate,1) clocks and never decreases.
- R11: A sweep step that would pass the end value lands exactly on it. Once at the end value, the sweep frequency holds there.
- R12: A high `clr_phase` at a clock edge zeroes the accumulator only. The sweep frequency and the registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable for the holding registers |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Write data |
| upd_stb | input | 1 | Copies holding registers into working registers |
| prof_sel | input | 3 | Profile select |
| clr_phase | input | 1 | Zeroes the accumulator |
| phase_word | output | 14 | Accumulator top bits plus offset |
| lut_addr | output | 10 | Sine table address |

## Verification
A corrupted accumulator shows up in `phase_word` in the same half-cycle, as a jump between consecutive samples. A wrong frequency word shows one edge later, because the difference between consecutive samples then departs from the programmed step. A fault in the modulus logic gives a wrong wrapped value within a few clocks of the first crossing of the modulus. A fault in the sweep counter or its clamp shows as a phase slope that changes one clock early or late, or that overshoots the end value. The bench therefore programs words that are exact multiples of 2^18 and compares each slope clock by clock.

// File: rtl/dds_pkg.sv
package dds_pkg;

    localparam int REG_ADDR_W = 4;

    // Control register layout, MSB first: bit 2 phase-profile, bit 1 sweep, bit 0 modulus
    typedef struct packed {
        logic phase_prof;
        logic sweep_en;
        logic mod_en;
    } ctrl_t;

    typedef enum logic [REG_ADDR_W-1:0] {
        ADDR_CTRL     = 4'd0,
        ADDR_BASE_FTW = 4'd1,
        ADDR_BASE_POW = 4'd2,
        ADDR_MODULUS  = 4'd3,
        ADDR_SW_START = 4'd4,
        ADDR_SW_END   = 4'd5,
        ADDR_SW_STEP  = 4'd6,
        ADDR_SW_RATE  = 4'd7
    } reg_addr_e;

    localparam int PROF_BASE = 8;

endpackage

// File: rtl/dds_regbank.sv
module dds_regbank #(
    parameter int FTW_W  = 32,
    parameter int POW_W  = 14,
    parameter int NPROF  = 8,
    parameter int RATE_W = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [dds_pkg::REG_ADDR_W-1:0] wr_addr,
    input  logic [FTW_W-1:0]              wr_data,
    input  logic                          upd_stb,
    output dds_pkg::ctrl_t                act_ctrl,
    output logic [FTW_W-1:0]              act_ftw,
    output logic [POW_W-1:0]              act_pow,
    output logic [FTW_W-1:0]              act_modulus,
    output logic [FTW_W-1:0]              act_sw_end,
    output logic [FTW_W-1:0]              act_sw_step,
    output logic [RATE_W-1:0]             act_sw_rate,
    output logic [NPROF-1:0][FTW_W-1:0]   act_prof,
    output logic                          sw_load,
    output logic [FTW_W-1:0]              sw_load_val
);
    import dds_pkg::*;

    typedef struct packed {
        ctrl_t                        ctrl;
        logic [FTW_W-1:0]             ftw;
        logic [POW_W-1:0]             pow;
        logic [FTW_W-1:0]             modulus;
        logic [FTW_W-1:0]             sw_start;
        logic [FTW_W-1:0]             sw_end;
        logic [FTW_W-1:0]             sw_step;
        logic [RATE_W-1:0]            sw_rate;
        logic [NPROF-1:0][FTW_W-1:0]  prof;
    } bank_t;

    typedef struct packed {
        bank_t shd;
        bank_t act;
    } state_t;

    state_t st_d, st_q;
    logic [NPROF-1:0] prof_hit;

    for (genvar gi = 0; gi < NPROF; gi++) begin : g_prof_hit
        assign prof_hit[gi] = wr_en && (wr_addr == REG_ADDR_W'(PROF_BASE + gi));
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL:     st_d.shd.ctrl     = ctrl_t'(wr_data[2:0]);
                ADDR_BASE_FTW: st_d.shd.ftw      = wr_data;
                ADDR_BASE_POW: st_d.shd.pow      = wr_data[POW_W-1:0];
                ADDR_MODULUS:  st_d.shd.modulus  = wr_data;
                ADDR_SW_START: st_d.shd.sw_start = wr_data;
                ADDR_SW_END:   st_d.shd.sw_end   = wr_data;
                ADDR_SW_STEP:  st_d.shd.sw_step  = wr_data;
                ADDR_SW_RATE:  st_d.shd.sw_rate  = wr_data[RATE_W-1:0];
                default: ;
            endcase
        end
        for (int i = 0; i < NPROF; i++) begin
            if (prof_hit[i]) st_d.shd.prof[i] = wr_data;
        end
        if (upd_stb) st_d.act = st_q.shd;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign act_ctrl    = st_q.act.ctrl;
    assign act_ftw     = st_q.act.ftw;
    assign act_pow     = st_q.act.pow;
    assign act_modulus = st_q.act.modulus;
    assign act_sw_end  = st_q.act.sw_end;
    assign act_sw_step = st_q.act.sw_step;
    assign act_sw_rate = st_q.act.sw_rate;
    assign act_prof    = st_q.act.prof;
    assign sw_load     = upd_stb && st_q.shd.ctrl.sweep_en;
    assign sw_load_val = st_q.shd.sw_start;

endmodule

// File: rtl/dds_sweep.sv
module dds_sweep #(
    parameter int FTW_W  = 32,
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [FTW_W-1:0]  start_val,
    input  logic              enable,
    input  logic [FTW_W-1:0]  end_val,
    input  logic [FTW_W-1:0]  step_val,
    input  logic [RATE_W-1:0] rate,
    output logic [FTW_W-1:0]  freq
);
    typedef struct packed {
        logic [FTW_W-1:0]  freq;
        logic [RATE_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;
    logic [RATE_W-1:0] last_cnt;
    logic [FTW_W-1:0]  room;

    always_comb begin
        st_d     = st_q;
        last_cnt = (rate == '0) ? '0 : rate - 1'b1;
        room     = end_val - st_q.freq;
        if (load) begin
            st_d.freq = start_val;
            st_d.cnt  = '0;
        end else if (enable) begin
            if (st_q.cnt >= last_cnt) begin
                st_d.cnt = '0;
                if (st_q.freq >= end_val) st_d.freq = st_q.freq;
                else if (room <= step_val) st_d.freq = end_val;
                else st_d.freq = st_q.freq + step_val;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign freq = st_q.freq;

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int FTW_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             mod_en,
    input  logic [FTW_W-1:0] modulus,
    input  logic [FTW_W-1:0] ftw,
    output logic [FTW_W-1:0] acc
);
    typedef struct packed {
        logic [FTW_W-1:0] acc;
    } state_t;

    state_t st_d, st_q;
    logic             carry;
    logic [FTW_W-1:0] low;
    logic             over;

    always_comb begin
        {carry, low} = {1'b0, st_q.acc} + {1'b0, ftw};
        over         = mod_en && (carry || (low >= modulus));
        st_d.acc     = over ? (low - modulus) : low;
        if (clr) st_d.acc = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign acc = st_q.acc;

endmodule

// File: rtl/dds_phase_engine.sv
module dds_phase_engine #(
    parameter int FTW_W  = 32,
    parameter int POW_W  = 14,
    parameter int LUT_W  = 10,
    parameter int NPROF  = 8,
    parameter int RATE_W = 16,
    localparam int PSEL_W = $clog2(NPROF),
    localparam int ADDR_W = dds_pkg::REG_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [FTW_W-1:0]  wr_data,
    input  logic              upd_stb,
    input  logic [PSEL_W-1:0] prof_sel,
    input  logic              clr_phase,
    output logic [POW_W-1:0]  phase_word,
    output logic [LUT_W-1:0]  lut_addr
);
    import dds_pkg::*;

    typedef struct packed {
        logic [PSEL_W-1:0] psel;
    } state_t;

    state_t st_d, st_q;

    ctrl_t                       act_ctrl;
    logic [FTW_W-1:0]            act_ftw;
    logic [POW_W-1:0]            act_pow;
    logic [FTW_W-1:0]            act_modulus;
    logic [FTW_W-1:0]            act_sw_end;
    logic [FTW_W-1:0]            act_sw_step;
    logic [RATE_W-1:0]           act_sw_rate;
    logic [NPROF-1:0][FTW_W-1:0] act_prof;
    logic                        sw_load;
    logic [FTW_W-1:0]            sw_load_val;
    logic [FTW_W-1:0]            sweep_freq;
    logic [FTW_W-1:0]            ftw_sel;
    logic [POW_W-1:0]            pow_sel;
    logic [FTW_W-1:0]            acc_q;
    logic [FTW_W-1:0]            prof_word;

    dds_regbank #(
        .FTW_W (FTW_W),
        .POW_W (POW_W),
        .NPROF (NPROF),
        .RATE_W(RATE_W)
    ) u_regbank (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .upd_stb    (upd_stb),
        .act_ctrl   (act_ctrl),
        .act_ftw    (act_ftw),
        .act_pow    (act_pow),
        .act_modulus(act_modulus),
        .act_sw_end (act_sw_end),
        .act_sw_step(act_sw_step),
        .act_sw_rate(act_sw_rate),
        .act_prof   (act_prof),
        .sw_load    (sw_load),
        .sw_load_val(sw_load_val)
    );

    dds_sweep #(
        .FTW_W (FTW_W),
        .RATE_W(RATE_W)
    ) u_sweep (
        .clk      (clk),
        .rst      (rst),
        .load     (sw_load),
        .start_val(sw_load_val),
        .enable   (act_ctrl.sweep_en),
        .end_val  (act_sw_end),
        .step_val (act_sw_step),
        .rate     (act_sw_rate),
        .freq     (sweep_freq)
    );

    always_comb begin
        st_d.psel = prof_sel;
        prof_word = act_prof[st_q.psel];
        if (act_ctrl.sweep_en)        ftw_sel = sweep_freq;
        else if (act_ctrl.phase_prof) ftw_sel = act_ftw;
        else                          ftw_sel = prof_word;
        pow_sel = act_ctrl.phase_prof ? prof_word[POW_W-1:0] : act_pow;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    dds_phase_acc #(
        .FTW_W(FTW_W)
    ) u_acc (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr_phase),
        .mod_en (act_ctrl.mod_en),
        .modulus(act_modulus),
        .ftw    (ftw_sel),
        .acc    (acc_q)
    );

    assign phase_word = acc_q[FTW_W-1 -: POW_W] + pow_sel;
    assign lut_addr   = phase_word[POW_W-1 -: LUT_W];

endmodule

// File: rtl/dds_phase_engine_chk.sv
module dds_phase_engine_chk #(
    parameter int FTW_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_phase,
    input logic             upd_stb,
    input dds_pkg::ctrl_t   act_ctrl,
    input logic [FTW_W-1:0] acc,
    input logic [FTW_W-1:0] ftw_sel,
    input logic [FTW_W-1:0] modulus,
    input logic [FTW_W-1:0] sweep_freq,
    input logic [FTW_W-1:0] sweep_end,
    input logic             sweep_load
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (acc == '0) && (sweep_freq == '0)); // R1

    AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
        (!act_ctrl.mod_en && !clr_phase) |=> acc == $past(acc) + $past(ftw_sel)); // R2

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        !upd_stb |=> $stable(act_ctrl) && $stable(modulus)); // R3

    AST_MOD_RANGE: assert property (@(posedge clk) disable iff (rst)
        (act_ctrl.mod_en && !upd_stb && (ftw_sel < modulus) && (acc < modulus))
        |=> acc < modulus); // R8

    AST_SWEEP_MONO: assert property (@(posedge clk) disable iff (rst)
        (act_ctrl.sweep_en && !sweep_load) |=> sweep_freq >= $past(sweep_freq)); // R10

    AST_SWEEP_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (act_ctrl.sweep_en && !sweep_load && (sweep_freq <= sweep_end))
        |=> sweep_freq <= $past(sweep_end)); // R11

    AST_CLR_ACC: assert property (@(posedge clk) disable iff (rst)
        clr_phase |=> acc == '0); // R12

endmodule

bind dds_phase_engine dds_phase_engine_chk #(.FTW_W(FTW_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr_phase (clr_phase),
    .upd_stb   (upd_stb),
    .act_ctrl  (act_ctrl),
    .acc       (acc_q),
    .ftw_sel   (ftw_sel),
    .modulus   (act_modulus),
    .sweep_freq(sweep_freq),
    .sweep_end (act_sw_end),
    .sweep_load(sw_load)
);

// File: tb/dds_phase_engine_bench.sv
`timescale 1ns/1ps
module dds_phase_engine_bench;
    localparam int UNIT = 1 << 18;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        upd_stb = 1'b0;
    logic [2:0]  prof_sel = '0;
    logic        clr_phase = 1'b0;
    logic [13:0] phase_word;
    logic [9:0]  lut_addr;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    dds_phase_engine u_dds_phase_engine (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .upd_stb   (upd_stb),
        .prof_sel  (prof_sel),
        .clr_phase (clr_phase),
        .phase_word(phase_word),
        .lut_addr  (lut_addr)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic upd();
        @(negedge clk); upd_stb = 1'b1;
        @(negedge clk); upd_stb = 1'b0;
    endtask

    task automatic clr();
        @(negedge clk); clr_phase = 1'b1;
        @(negedge clk); clr_phase = 1'b0;
    endtask

    function automatic int diff14(input logic [13:0] a, input logic [13:0] b);
        logic [13:0] d;
        d = b - a;
        return int'(d);
    endfunction

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 phase in reset", int'(phase_word), 0);
        check("R1 lut in reset", int'(lut_addr), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 idle after reset", int'(phase_word), 0);
    endtask

    task automatic t_accumulate();
        wr(4'd8, UNIT);       // R4 profile 0
        wr(4'd9, 5 * UNIT);   // R4 profile 1
        wr(4'd0, 0);          // R4 control: frequency profiles
        upd();
        clr();
        check("R12 clear to zero", int'(phase_word), 0);
        repeat (5) @(negedge clk);
        check("R2 five steps", int'(phase_word), 5);
    endtask

    task automatic t_update_gating();
        logic [13:0] p0;
        wr(4'd8, 2 * UNIT);
        @(negedge clk); p0 = phase_word;
        @(negedge clk);
        check("R3 held write ignored", diff14(p0, phase_word), 1);
        upd();
        p0 = phase_word;
        @(negedge clk);
        check("R3 update applies word", diff14(p0, phase_word), 2);
        wr(4'd2, 7);          // R4 base offset
        clr();
        check("R3 held offset ignored", int'(phase_word), 0);
        upd();
        clr();
        check("R5 base offset used", int'(phase_word), 7);
    endtask

    task automatic t_profile_switch();
        logic [13:0] p0, p1;
        @(negedge clk);
        p0 = phase_word;
        prof_sel = 3'd1;
        @(negedge clk); p1 = phase_word;
        check("R7 first edge keeps old word", diff14(p0, p1), 2);
        @(negedge clk);
        check("R5 R7 new profile word", diff14(p1, phase_word), 5);
    endtask

    task automatic t_phase_mode();
        logic [13:0] p0, p1;
        wr(4'd2, 0);
        wr(4'd1, UNIT);       // R4 base frequency
        wr(4'd11, 100);       // profile 3 offset
        wr(4'd12, 16383);     // profile 4 offset
        wr(4'd0, 4);          // R4 control bit 2
        @(negedge clk); prof_sel = 3'd3;
        upd();
        clr();
        check("R6 profile offset", int'(phase_word), 100);
        check("R2 lut address", int'(lut_addr), 100 >> 4);
        @(negedge clk);
        p0 = phase_word;
        prof_sel = 3'd4;
        @(negedge clk); p1 = phase_word;
        check("R6 R2 offset wraps mod 2^14", int'(p1), int'(p0 - 14'd100));
        check("R2 lut follows phase", int'(lut_addr), int'(p1) >> 4);
    endtask

    task automatic t_modulus();
        int exp_seq[10] = '{3, 6, 9, 2, 5, 8, 1, 4, 7, 0};
        @(negedge clk); prof_sel = 3'd0;
        wr(4'd8, 3 * UNIT);
        wr(4'd3, 10 * UNIT);  // R4 modulus
        wr(4'd2, 0);
        wr(4'd0, 1);          // R4 control bit 0
        upd();
        clr();
        check("R8 start at zero", int'(phase_word), 0);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check("R8 modulus wrap", int'(phase_word), exp_seq[k]);
        end
    endtask

    task automatic t_sweep();
        logic [13:0] prev;
        int exp;
        wr(4'd4, UNIT);       // R4 sweep start
        wr(4'd5, 6 * UNIT);   // R4 sweep end
        wr(4'd6, 2 * UNIT);   // R4 sweep step
        wr(4'd7, 3);          // R4 sweep rate
        wr(4'd0, 2);          // R4 control bit 1
        upd();
        prev = phase_word;
        for (int k = 1; k <= 14; k++) begin
            @(negedge clk);
            exp = (k <= 3) ? 1 : (k <= 6) ? 3 : (k <= 9) ? 5 : 6;
            check("R9 R10 R11 sweep slope", diff14(prev, phase_word), exp);
            prev = phase_word;
        end
        wr(4'd7, 1);
        wr(4'd4, 2 * UNIT);
        upd();
        prev = phase_word;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            exp = (k == 1) ? 2 : (k == 2) ? 4 : 6;
            check("R9 R10 reload rate one", diff14(prev, phase_word), exp);
            prev = phase_word;
        end
    endtask

    task automatic t_clear();
        clr();
        check("R12 clear during sweep", int'(phase_word), 0);
        @(negedge clk);
        check("R12 sweep word kept", int'(phase_word), 6);
    endtask

    task automatic t_reset_mid();
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid run", int'(phase_word), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 registers cleared", int'(phase_word), 0);
    endtask

    initial begin
        t_reset();
        t_accumulate();
        t_update_gating();
        t_profile_switch();
        t_phase_mode();
        t_modulus();
        t_sweep();
        t_clear();
        t_reset_mid();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule